// File: doc/BRIEF.md
# Segmented Memory Mapper with Activity Tracking

This block sits between an 8-bit CPU with a 16-bit address bus and a wider external memory. It splits the CPU's 64K space into eight 8K windows. Each window is steered to any one of 128 physical 8K pages through a small page table. The table is written and read back by CPU I/O cycles. Every table entry also carries a protect flag. A write into a protected window never reaches memory, so that window acts as ROM.

Two complete page tables are held: one for ordinary (user) execution and one for the supervisor. The supervisor table is selected whenever the supervisor input is high, for example while an NMI handler runs. Two activity bytes record which windows have been read and which have been written since software last cleared them. An operating system can use them to build a virtual-memory or swapping policy.

Translation is purely combinational from the address bus to the physical address and memory strobes. Table updates and activity bits take effect at the next rising clock edge.

Top module: `segmap_unit`

## Requirements
- R1: After reset, in both tables, window n maps to page n with the protect flag clear, and both activity bytes read 0x00.
- R2: The physical address is the 7-bit page of the entry chosen by CPU address bits 15..13, with CPU address bits 12..0 appended unchanged below it. It appears in the same cycle as the address.
- R3: An I/O write to low address byte 0xC0+n (n = 0..7) loads the user entry of window n. An I/O write to 0xC8+n loads the supervisor entry of window n. Entry bit 7 is the protect flag and bits 6..0 are the page. An I/O read at the same address returns the entry. CPU address bits 15..8 are ignored for I/O decode.
- R4: While the active entry has its protect flag set, a memory write produces no memory write strobe. A memory read of the same window still produces the read strobe.
- R5: One physical page may be mapped into several windows at the same time, and each of those windows translates to it.
- R6: A memory write that produces a write strobe sets bit n of the dirty byte (I/O address 0xD0), where n is the window. A write blocked by protection leaves the dirty byte unchanged.
- R7: A memory read that produces a read strobe sets bit n of the access byte (I/O address 0xD1).
- R8: An I/O write to 0xD0 or 0xD1 clears each bit where the written data has a 1 and leaves bits written with 0 unchanged.
- R9: The supervisor table drives translation and protection when sup_mode is 1, and the user table drives them when sup_mode is 0. Writing one table never alters the other.
- R10: A cycle counts as a memory cycle only when mreq is high with rfsh and io_req low. Refresh cycles and I/O cycles raise no memory strobe and leave both activity bytes unchanged.
- R11: I/O writes outside the decoded addresses (0xC0..0xCF, 0xD0, 0xD1) change no state. I/O reads at undecoded addresses, and cycles that are not I/O reads, return 0x00 on io_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU data for I/O writes |
| mreq | input | 1 | Memory request |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| rfsh | input | 1 | Refresh cycle indicator |
| io_req | input | 1 | I/O request |
| sup_mode | input | 1 | 1 selects the supervisor table |
| phys_addr | output | 20 | Translated physical address |
| mem_rd_en | output | 1 | Qualified memory read strobe |
| mem_wr_en | output | 1 | Qualified, protection-checked memory write strobe |
| io_rdata | output | 8 | I/O read-back data |

## Verification
A corrupted table entry shows up in phys_addr or in a missing write strobe in the very cycle that its window is addressed. It also shows up on io_rdata at the next read-back of that entry. A wrong activity bit cannot be seen until software reads 0xD0 or 0xD1, so the bench reads both bytes right after each set, clear and refresh case. A mix-up between the two tables stays hidden until sup_mode toggles, so translation is compared in both modes after each table is loaded with different contents.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
    localparam int SEG_N   = 8;
    localparam int SEG_W   = $clog2(SEG_N);
    localparam int PAGE_W  = 7;
    localparam int OFS_W   = 13;
    localparam int ENTRY_W = PAGE_W + 1;
    localparam int DATA_W  = 8;
    localparam int CPU_AW  = SEG_W + OFS_W;
    localparam int PHYS_W  = PAGE_W + OFS_W;
    localparam int FILE_N  = 2;
    localparam int IOA_W   = 8;
    localparam int BASE_W  = IOA_W - 5;

    typedef struct packed {
        logic              wp;
        logic [PAGE_W-1:0] page;
    } page_entry_t;

    function automatic page_entry_t identity_entry(int idx);
        page_entry_t e;
        e.wp   = 1'b0;
        e.page = PAGE_W'(idx);
        return e;
    endfunction
endpackage

// File: rtl/segmap_pagefile.sv
module segmap_pagefile
    import segmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  page_entry_t      wr_entry,
    input  logic [SEG_W-1:0] look_idx,
    output page_entry_t      look_entry,
    input  logic [SEG_W-1:0] peek_idx,
    output page_entry_t      peek_entry
);
    typedef struct packed {
        page_entry_t [SEG_N-1:0] ent;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SEG_N; i++) begin
                st_q.ent[i] <= identity_entry(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign look_entry = st_q.ent[look_idx];
    assign peek_entry = st_q.ent[peek_idx];
endmodule

// File: rtl/segmap_tracker.sv
module segmap_tracker
    import segmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_idx,
    input  logic             rd_hit,
    input  logic             wr_hit,
    input  logic             clr_dirty,
    input  logic             clr_access,
    input  logic [SEG_N-1:0] clr_mask,
    output logic [SEG_N-1:0] dirty,
    output logic [SEG_N-1:0] access
);
    typedef struct packed {
        logic [SEG_N-1:0] dirty;
        logic [SEG_N-1:0] access;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_dirty) begin
            st_d.dirty = st_q.dirty & ~clr_mask;
        end
        if (clr_access) begin
            st_d.access = st_q.access & ~clr_mask;
        end
        // a new hit in the same cycle outranks a clear, so no activity is lost
        if (wr_hit) begin
            st_d.dirty[seg_idx] = 1'b1;
        end
        if (rd_hit) begin
            st_d.access[seg_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dirty  = st_q.dirty;
    assign access = st_q.access;
endmodule

// File: rtl/segmap_iodec.sv
module segmap_iodec
    import segmap_pkg::*;
#(
    parameter logic [BASE_W-1:0] IO_BASE = 3'b110
) (
    input  logic [IOA_W-1:0] io_addr,
    input  logic             io_req,
    input  logic             rd,
    input  logic             wr,
    output logic             io_rd,
    output logic             io_wr,
    output logic             sel_page,
    output logic             sel_file,
    output logic [SEG_W-1:0] sel_seg,
    output logic             sel_dirty,
    output logic             sel_access
);
    logic in_win;
    logic sel_trk;

    always_comb begin
        in_win     = (io_addr[IOA_W-1:5] == IO_BASE);
        sel_page   = in_win && !io_addr[4];
        sel_trk    = in_win && io_addr[4] && (io_addr[3:1] == 3'b000);
        sel_dirty  = sel_trk && !io_addr[0];
        sel_access = sel_trk && io_addr[0];
        sel_file   = io_addr[3];
        sel_seg    = io_addr[SEG_W-1:0];
        io_rd      = io_req && rd;
        io_wr      = io_req && wr;
    end
endmodule

// File: rtl/segmap_unit.sv
module segmap_unit
    import segmap_pkg::*;
#(
    parameter logic [BASE_W-1:0] IO_BASE = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              mreq,
    input  logic              rd,
    input  logic              wr,
    input  logic              rfsh,
    input  logic              io_req,
    input  logic              sup_mode,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] io_rdata
);
    logic             io_rd, io_wr;
    logic             sel_page, sel_file, sel_dirty, sel_access;
    logic [SEG_W-1:0] sel_seg;
    logic [SEG_W-1:0] seg;
    logic             mem_cyc;
    logic             act_wp;
    page_entry_t      act;
    page_entry_t      look_e [FILE_N];
    page_entry_t      peek_e [FILE_N];
    logic [SEG_N-1:0] trk_dirty, trk_access;

    assign seg = cpu_addr[CPU_AW-1:OFS_W];

    segmap_iodec #(.IO_BASE(IO_BASE)) u_dec (
        .io_addr   (cpu_addr[IOA_W-1:0]),
        .io_req    (io_req),
        .rd        (rd),
        .wr        (wr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .sel_page  (sel_page),
        .sel_file  (sel_file),
        .sel_seg   (sel_seg),
        .sel_dirty (sel_dirty),
        .sel_access(sel_access)
    );

    for (genvar f = 0; f < FILE_N; f++) begin : g_file
        segmap_pagefile u_pf (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (io_wr && sel_page && (sel_file == 1'(f))),
            .wr_idx    (sel_seg),
            .wr_entry  (page_entry_t'(cpu_wdata[ENTRY_W-1:0])),
            .look_idx  (seg),
            .look_entry(look_e[f]),
            .peek_idx  (sel_seg),
            .peek_entry(peek_e[f])
        );
    end

    always_comb begin
        act       = look_e[sup_mode];
        act_wp    = act.wp;
        mem_cyc   = mreq && !rfsh && !io_req;
        mem_rd_en = mem_cyc && rd;
        mem_wr_en = mem_cyc && wr && !act_wp;
        phys_addr = {act.page, cpu_addr[OFS_W-1:0]};
    end

    segmap_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_idx   (seg),
        .rd_hit    (mem_rd_en),
        .wr_hit    (mem_wr_en),
        .clr_dirty (io_wr && sel_dirty),
        .clr_access(io_wr && sel_access),
        .clr_mask  (cpu_wdata[SEG_N-1:0]),
        .dirty     (trk_dirty),
        .access    (trk_access)
    );

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (sel_page) begin
                io_rdata = DATA_W'(peek_e[sel_file]);
            end else if (sel_dirty) begin
                io_rdata = DATA_W'(trk_dirty);
            end else if (sel_access) begin
                io_rdata = DATA_W'(trk_access);
            end
        end
    end
endmodule

// File: rtl/segmap_checker.sv
module segmap_checker
    import segmap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              mreq,
    input logic              rfsh,
    input logic              io_req,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              act_wp,
    input logic [SEG_N-1:0]  dirty,
    input logic [SEG_N-1:0]  access
);
    p_ofs_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);

    p_wp_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !act_wp);

    p_strobe_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> (mreq && !rfsh && !io_req));

    p_dirty_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((dirty & ~$past(dirty)) != '0) |-> $past(mem_wr_en));

    p_access_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((access & ~$past(access)) != '0) |-> $past(mem_rd_en));

    p_rfsh_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rfsh) |-> (((dirty & ~$past(dirty)) == '0) && ((access & ~$past(access)) == '0)));
endmodule

bind segmap_unit segmap_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .phys_addr(phys_addr),
    .mreq     (mreq),
    .rfsh     (rfsh),
    .io_req   (io_req),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .act_wp   (act_wp),
    .dirty    (trk_dirty),
    .access   (trk_access)
);

// File: tb/test_segmap_unit.sv
`timescale 1ns/1ps
module test_segmap_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        mreq, rd, wr, rfsh, io_req, sup_mode;
    logic [19:0] phys_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  io_rdata;

    always #2.5 clk = ~clk;

    segmap_unit i_segmap_unit (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .mreq(mreq), .rd(rd), .wr(wr), .rfsh(rfsh), .io_req(io_req),
        .sup_mode(sup_mode), .phys_addr(phys_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .io_rdata(io_rdata)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] m_user [8];
    logic [7:0] m_sup  [8];
    logic [7:0] m_dirty, m_access;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_user[i] = 8'(i);
            m_sup[i]  = 8'(i);
        end
        m_dirty  = 8'h00;
        m_access = 8'h00;
    endtask

    function automatic bit io_hit(logic [15:0] a);
        return (a[7:5] == 3'b110) && (!a[4] || (a[3:1] == 3'b000));
    endfunction

    function automatic logic [7:0] io_value(logic [15:0] a);
        if (!a[4]) return a[3] ? m_sup[a[2:0]] : m_user[a[2:0]];
        return a[0] ? m_access : m_dirty;
    endfunction

    task automatic step(string tag, bit mq, bit r, bit w, bit rf, bit io, bit sp,
                        logic [15:0] a, logic [7:0] d);
        logic [7:0]  ent;
        bit          mc, erd, ewr;
        logic [19:0] ephys;
        logic [7:0]  erdata;
        mreq = mq; rd = r; wr = w; rfsh = rf; io_req = io; sup_mode = sp;
        cpu_addr = a; cpu_wdata = d;
        #1;
        ent    = sp ? m_sup[a[15:13]] : m_user[a[15:13]];
        mc     = mq && !rf && !io;
        erd    = mc && r;
        ewr    = mc && w && !ent[7];
        ephys  = {ent[6:0], a[12:0]};
        erdata = (io && r && io_hit(a)) ? io_value(a) : 8'h00;
        total++;
        if ({phys_addr, mem_rd_en, mem_wr_en, io_rdata} !== {ephys, erd, ewr, erdata}) begin
            bad++;
            $display("FAIL %s addr=%h: got phys=%h rd=%b wr=%b io=%h exp phys=%h rd=%b wr=%b io=%h",
                     tag, a, phys_addr, mem_rd_en, mem_wr_en, io_rdata, ephys, erd, ewr, erdata);
        end
        @(posedge clk);
        if (io && w && io_hit(a)) begin
            if (!a[4]) begin
                if (a[3]) m_sup[a[2:0]] = d;
                else      m_user[a[2:0]] = d;
            end else if (a[0]) begin
                m_access = m_access & ~d;
            end else begin
                m_dirty = m_dirty & ~d;
            end
        end
        if (ewr) m_dirty[a[15:13]] = 1'b1;
        if (erd) m_access[a[15:13]] = 1'b1;
        @(negedge clk);
    endtask

    task automatic iowr(string tag, logic [15:0] a, logic [7:0] d);
        step(tag, 0, 0, 1, 0, 1, 0, a, d);
    endtask
    task automatic iord(string tag, logic [15:0] a);
        step(tag, 0, 1, 0, 0, 1, 0, a, 8'h00);
    endtask
    task automatic memrd(string tag, bit sp, logic [15:0] a);
        step(tag, 1, 1, 0, 0, 0, sp, a, 8'h00);
    endtask
    task automatic memwr(string tag, bit sp, logic [15:0] a);
        step(tag, 1, 0, 1, 0, 0, sp, a, 8'h5A);
    endtask
    task automatic look(string tag, bit sp, logic [15:0] a);
        step(tag, 0, 0, 0, 0, 0, sp, a, 8'h00);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no finish exp finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mreq = 0; rd = 0; wr = 0; rfsh = 0; io_req = 0; sup_mode = 0;
        cpu_addr = '0; cpu_wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents and identity translation
        for (int i = 0; i < 16; i++) iord("R1", 16'h00C0 + 16'(i));
        iord("R1", 16'h00D0);
        iord("R1", 16'h00D1);
        for (int i = 0; i < 8; i++) begin
            look("R1", 0, {3'(i), 13'h0155});
            look("R1", 1, {3'(i), 13'h1AAA});
        end

        // R3 table writes and read-back, upper I/O bits ignored
        iowr("R3", 16'h00C1, 8'h33);
        iowr("R3", 16'h00C5, 8'h33);
        iowr("R3", 16'h00C2, 8'h92);
        iowr("R3", 16'h00C3, 8'h7F);
        iowr("R3", 16'h00C7, 8'h40);
        iowr("R3", 16'hABC4, 8'h21);
        for (int i = 0; i < 8; i++) iord("R3", 16'h55C0 + 16'(i));

        // R2 translation at both ends of each window
        for (int i = 0; i < 8; i++) begin
            look("R2", 0, {3'(i), 13'h0000});
            look("R2", 0, {3'(i), 13'h1FFF});
        end

        // R5 aliasing of one page in two windows
        memrd("R5", 0, 16'h2ABC);
        memrd("R5", 0, 16'hAABC);

        // R4 protected window, then R6 blocked write leaves dirty clear
        memwr("R4", 0, 16'h4010);
        memrd("R4", 0, 16'h4010);
        iord("R6", 16'h00D0);
        iord("R7", 16'h00D1);

        // R6 and R7 setting
        memwr("R6", 0, 16'h6000);
        memwr("R6", 0, 16'hFFFF);
        iord("R6", 16'h00D0);
        memrd("R7", 0, 16'h8001);
        iord("R7", 16'h00D1);

        // R8 write-one-to-clear
        iowr("R8", 16'h00D0, 8'h00);
        iord("R8", 16'h00D0);
        iowr("R8", 16'h00D0, 8'h08);
        iord("R8", 16'h00D0);
        iowr("R8", 16'h00D1, 8'hFF);
        iord("R8", 16'h00D1);

        // R9 supervisor table independent and selected by sup_mode
        for (int i = 0; i < 8; i++) iowr("R9", 16'h00C8 + 16'(i), 8'(8'h60 + i));
        iowr("R9", 16'h00C8, 8'hE0);
        for (int i = 0; i < 16; i++) iord("R9", 16'h00C0 + 16'(i));
        for (int i = 0; i < 8; i++) begin
            look("R9", 1, {3'(i), 13'h0777});
            look("R9", 0, {3'(i), 13'h0777});
        end
        memwr("R9", 1, 16'h0100);
        memwr("R9", 0, 16'h0100);
        iord("R9", 16'h00D0);

        // R10 refresh and I/O cycles do not track
        iowr("R10", 16'h00D0, 8'hFF);
        iowr("R10", 16'h00D1, 8'hFF);
        step("R10", 1, 1, 0, 1, 0, 0, 16'hE000, 8'h00);
        step("R10", 1, 0, 1, 1, 0, 0, 16'hC000, 8'h00);
        step("R10", 1, 1, 0, 0, 1, 0, 16'h20C0, 8'h00);
        iord("R10", 16'h00D0);
        iord("R10", 16'h00D1);

        // R11 undecoded I/O addresses
        iowr("R11", 16'h00A3, 8'hFF);
        iowr("R11", 16'h00D4, 8'hFF);
        iowr("R11", 16'h00E1, 8'hFF);
        for (int i = 0; i < 16; i++) iord("R11", 16'h00C0 + 16'(i));
        iord("R11", 16'h00D0);
        iord("R11", 16'h00D1);
        iord("R11", 16'h00D4);
        iord("R11", 16'h00A3);

        // R2 mixed traffic against the model
        for (int k = 0; k < 600; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            step("R2", rv[0], rv[1], rv[2], rv[3] & rv[4], rv[5] & rv[6], rv[7],
                 {rv[15:8], rv[8] ? 3'b110 : rv[18:16], rv[23:19]}, rv[31:24]);
        end
        for (int i = 0; i < 16; i++) iord("R3", 16'h00C0 + 16'(i));
        iord("R6", 16'h00D0);
        iord("R7", 16'h00D1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule